// File: doc/BRIEF.md
# Register Update Queue

This block is the in-flight instruction window of an out-of-order core. It is a circular queue with one slot for each instruction between dispatch and retirement. Dispatch writes a new instruction into the slot at the tail. Each slot records the instruction address, the number of the execution unit it needs, whether it is a memory operation, and two source operands. Each source operand is either a value that is already known or the tag of the producer it is waiting for. The slot also holds a destination tag, a destination value, and two progress flags: issued and executed.

Each cycle the block does four things at once:
- **Accept:** it takes at most one new instruction at the tail.
- **Capture:** it watches the result bus and loads matching data into waiting operands.
- **Issue:** for every execution unit that is ready, it picks one slot whose two operands are both known.
- **Retire:** it retires the head slot once that slot has executed. The value goes to the register file, and the same tag and value are broadcast to operands that are still waiting.

Because retirement only happens at the head, register writes occur in program order.

Top module: `ruq_top`

## Requirements
- R1: The queue holds DEPTH instructions. `disp_full` is high exactly while DEPTH slots are occupied. A dispatch offered while `disp_full` is high is ignored: the tail does not move and no extra instruction ever retires. `disp_full` falls in the cycle after a retirement frees a slot.
- R2: `disp_idx` gives the slot index that the next accepted dispatch will occupy. It steps by one per accepted dispatch and wraps from DEPTH-1 to 0.
- R3: A source dispatched with its ready flag high keeps the supplied value, and that value is presented on the operand output when the slot issues.
- R4: A source dispatched not ready captures the result-bus data when `rb_valid` is high and `rb_tag` equals its stored tag. This includes a broadcast in the same cycle as its dispatch. A broadcast with a different tag leaves the source waiting, so the slot does not issue.
- R5: A result-bus broadcast with index `rb_idx` stores `rb_data` in that slot and marks it executed. When that slot is at the head, it retires in the next cycle: `cm_valid` is high, and `cm_tag`/`cm_data` carry its destination tag and the broadcast value.
- R6: Unit f is offered at most one slot per cycle. A slot is offered to unit f only when:
  - it is occupied and not yet issued,
  - both of its sources are ready,
  - its unit number is f,
  - and `fu_ready[f]` is high.

  A slot that has been offered is marked issued and is never offered again.
- R7: Among the candidates for one unit, a slot with `disp_mem` set wins. Among candidates of the same kind, the slot closest to the head (the oldest) wins.
- R8: Slots retire strictly in dispatch order, at most one per cycle. A younger slot that has executed waits until every older slot has retired.
- R9: A retirement broadcasts `cm_tag`/`cm_data` to waiting sources, including a source dispatched in the same cycle. A matching source becomes ready with `cm_data`.
- R10: After reset the queue is empty: `disp_full` is low, `cm_valid` is low, `iss_valid` is all zero, and `disp_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_pc | input | PC_W | Instruction address |
| disp_fu | input | FU_W | Execution unit number |
| disp_mem | input | 1 | Instruction is a load or store |
| disp_s1_rdy | input | 1 | Source 1 value is known |
| disp_s1_tag | input | TAG_W | Source 1 producer tag |
| disp_s1_val | input | DATA_W | Source 1 value |
| disp_s2_rdy | input | 1 | Source 2 value is known |
| disp_s2_tag | input | TAG_W | Source 2 producer tag |
| disp_s2_val | input | DATA_W | Source 2 value |
| disp_dst_tag | input | TAG_W | Destination tag (register number and instance) |
| disp_full | output | 1 | Queue full; dispatch ignored |
| disp_idx | output | IDX_W | Slot the next dispatch takes |
| rb_valid | input | 1 | Result-bus broadcast |
| rb_idx | input | IDX_W | Slot that produced the result |
| rb_tag | input | TAG_W | Destination tag of the result |
| rb_data | input | DATA_W | Result value |
| fu_ready | input | NUM_FU | Unit can accept an instruction |
| iss_valid | output | NUM_FU | Issue to unit f this cycle |
| iss_idx | output | NUM_FU*IDX_W | Issued slot, per unit |
| iss_pc | output | NUM_FU*PC_W | Issued instruction address, per unit |
| iss_op1 | output | NUM_FU*DATA_W | Source 1 value, per unit |
| iss_op2 | output | NUM_FU*DATA_W | Source 2 value, per unit |
| iss_dst_tag | output | NUM_FU*TAG_W | Destination tag, per unit |
| cm_valid | output | 1 | Head retires; register write and instance-count decrement |
| cm_tag | output | TAG_W | Retiring destination tag |
| cm_data | output | DATA_W | Retiring value |

## Verification
The bench builds the queue with DEPTH=4 and NUM_FU=2. Four dispatches therefore fill it, and one pass through the scenario wraps both the head and the tail past the last slot. The age check is made on slots that lie on either side of the wrap point. With only two units, a memory slot and an older ordinary slot compete for the same unit, which exercises the priority order. A retirement is also timed to coincide with the dispatch of its consumer, so the retirement-broadcast path is exercised.

// File: rtl/ruq_pkg.sv
package ruq_pkg;

    localparam int DATA_W = 32;
    localparam int TAG_W  = 8;
    localparam int PC_W   = 32;
    localparam int FU_W   = 2;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } src_t;

    typedef struct packed {
        logic              valid;
        logic [PC_W-1:0]   pc;
        logic [FU_W-1:0]   fu;
        logic              is_mem;
        logic              issued;
        logic              executed;
        src_t              s1;
        src_t              s2;
        logic [TAG_W-1:0]  dst_tag;
        logic [DATA_W-1:0] dst_val;
    } ent_t;

endpackage

// File: rtl/ruq_src_cap.sv
// Operand capture: a waiting source takes data from the result bus,
// or otherwise from the retirement broadcast, when the tag matches.
module ruq_src_cap
    import ruq_pkg::*;
(
    input  src_t              cur,
    input  logic              bus_v,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              cm_v,
    input  logic [TAG_W-1:0]  cm_tag,
    input  logic [DATA_W-1:0] cm_data,
    output src_t              nxt
);
    always_comb begin
        nxt = cur;
        if (!cur.rdy && bus_v && cur.tag == bus_tag) begin
            nxt.rdy = 1'b1;
            nxt.val = bus_data;
        end else if (!cur.rdy && cm_v && cur.tag == cm_tag) begin
            nxt.rdy = 1'b1;
            nxt.val = cm_data;
        end
    end
endmodule

// File: rtl/ruq_pick.sv
// Age-ordered picker: memory requests first, then oldest from head.
module ruq_pick #(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] req,
    input  logic [DEPTH-1:0] mem,
    input  logic [IDX_W-1:0] head,
    output logic             gnt_v,
    output logic [IDX_W-1:0] gnt_idx
);
    logic             found_m, found_o;
    logic [IDX_W-1:0] idx_m, idx_o, p;

    always_comb begin
        found_m = 1'b0;
        found_o = 1'b0;
        idx_m   = '0;
        idx_o   = '0;
        p       = '0;
        for (int k = 0; k < DEPTH; k++) begin
            p = IDX_W'((int'(head) + k) % DEPTH);
            if (req[p] && mem[p] && !found_m) begin
                found_m = 1'b1;
                idx_m   = p;
            end
            if (req[p] && !found_o) begin
                found_o = 1'b1;
                idx_o   = p;
            end
        end
        gnt_v   = found_o;
        gnt_idx = found_m ? idx_m : idx_o;
    end
endmodule

// File: rtl/ruq_top.sv
module ruq_top
    import ruq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int NUM_FU = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     disp_valid,
    input  logic [PC_W-1:0]          disp_pc,
    input  logic [FU_W-1:0]          disp_fu,
    input  logic                     disp_mem,
    input  logic                     disp_s1_rdy,
    input  logic [TAG_W-1:0]         disp_s1_tag,
    input  logic [DATA_W-1:0]        disp_s1_val,
    input  logic                     disp_s2_rdy,
    input  logic [TAG_W-1:0]         disp_s2_tag,
    input  logic [DATA_W-1:0]        disp_s2_val,
    input  logic [TAG_W-1:0]         disp_dst_tag,
    output logic                     disp_full,
    output logic [IDX_W-1:0]         disp_idx,
    input  logic                     rb_valid,
    input  logic [IDX_W-1:0]         rb_idx,
    input  logic [TAG_W-1:0]         rb_tag,
    input  logic [DATA_W-1:0]        rb_data,
    input  logic [NUM_FU-1:0]        fu_ready,
    output logic [NUM_FU-1:0]        iss_valid,
    output logic [NUM_FU*IDX_W-1:0]  iss_idx,
    output logic [NUM_FU*PC_W-1:0]   iss_pc,
    output logic [NUM_FU*DATA_W-1:0] iss_op1,
    output logic [NUM_FU*DATA_W-1:0] iss_op2,
    output logic [NUM_FU*TAG_W-1:0]  iss_dst_tag,
    output logic                     cm_valid,
    output logic [TAG_W-1:0]         cm_tag,
    output logic [DATA_W-1:0]        cm_data
);
    ent_t             ent [DEPTH];
    logic [IDX_W-1:0] head, tail;
    logic [CNT_W-1:0] count;
    logic             disp_go;
    src_t             s1_nxt [DEPTH];
    src_t             s2_nxt [DEPTH];
    src_t             d1_cur, d2_cur, d1_nxt, d2_nxt;
    ent_t             new_ent;
    logic [DEPTH-1:0] mem_vec;
    logic [NUM_FU-1:0] gnt_v;
    logic [IDX_W-1:0] gnt_idx [NUM_FU];

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Occupancy and retirement (R1, R5, R8)
    assign disp_full = (count == CNT_W'(DEPTH));
    assign disp_go   = disp_valid && !disp_full;
    assign disp_idx  = tail;
    assign cm_valid  = ent[head].valid && ent[head].executed;
    assign cm_tag    = ent[head].dst_tag;
    assign cm_data   = ent[head].dst_val;

    // Operand capture for resident slots and for the dispatch path (R4, R9)
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        ruq_src_cap u_cap1 (
            .cur(ent[i].s1), .bus_v(rb_valid), .bus_tag(rb_tag), .bus_data(rb_data),
            .cm_v(cm_valid), .cm_tag(cm_tag), .cm_data(cm_data), .nxt(s1_nxt[i])
        );
        ruq_src_cap u_cap2 (
            .cur(ent[i].s2), .bus_v(rb_valid), .bus_tag(rb_tag), .bus_data(rb_data),
            .cm_v(cm_valid), .cm_tag(cm_tag), .cm_data(cm_data), .nxt(s2_nxt[i])
        );
    end

    assign d1_cur = '{rdy: disp_s1_rdy, tag: disp_s1_tag, val: disp_s1_val};
    assign d2_cur = '{rdy: disp_s2_rdy, tag: disp_s2_tag, val: disp_s2_val};

    ruq_src_cap u_dcap1 (
        .cur(d1_cur), .bus_v(rb_valid), .bus_tag(rb_tag), .bus_data(rb_data),
        .cm_v(cm_valid), .cm_tag(cm_tag), .cm_data(cm_data), .nxt(d1_nxt)
    );
    ruq_src_cap u_dcap2 (
        .cur(d2_cur), .bus_v(rb_valid), .bus_tag(rb_tag), .bus_data(rb_data),
        .cm_v(cm_valid), .cm_tag(cm_tag), .cm_data(cm_data), .nxt(d2_nxt)
    );

    always_comb begin
        new_ent          = '0;
        new_ent.valid    = 1'b1;
        new_ent.pc       = disp_pc;
        new_ent.fu       = disp_fu;
        new_ent.is_mem   = disp_mem;
        new_ent.s1       = d1_nxt;
        new_ent.s2       = d2_nxt;
        new_ent.dst_tag  = disp_dst_tag;
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_vec[i] = ent[i].is_mem;
    end

    // Per-unit issue selection (R6, R7)
    for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
        logic [DEPTH-1:0] req;
        always_comb begin
            for (int i = 0; i < DEPTH; i++) begin
                req[i] = ent[i].valid && !ent[i].issued && ent[i].s1.rdy &&
                         ent[i].s2.rdy && (ent[i].fu == FU_W'(f)) && fu_ready[f];
            end
        end
        ruq_pick #(.DEPTH(DEPTH)) u_pick (
            .req(req), .mem(mem_vec), .head(head),
            .gnt_v(gnt_v[f]), .gnt_idx(gnt_idx[f])
        );
        assign iss_idx[f*IDX_W +: IDX_W]      = gnt_idx[f];
        assign iss_pc[f*PC_W +: PC_W]         = ent[gnt_idx[f]].pc;
        assign iss_op1[f*DATA_W +: DATA_W]    = ent[gnt_idx[f]].s1.val;
        assign iss_op2[f*DATA_W +: DATA_W]    = ent[gnt_idx[f]].s2.val;
        assign iss_dst_tag[f*TAG_W +: TAG_W]  = ent[gnt_idx[f]].dst_tag;
    end
    assign iss_valid = gnt_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                ent[i].s1 <= s1_nxt[i];
                ent[i].s2 <= s2_nxt[i];
                if (rb_valid && rb_idx == IDX_W'(i) && ent[i].valid) begin
                    ent[i].executed <= 1'b1;
                    ent[i].dst_val  <= rb_data;
                end
                for (int f = 0; f < NUM_FU; f++) begin
                    if (gnt_v[f] && gnt_idx[f] == IDX_W'(i)) ent[i].issued <= 1'b1;
                end
                if (cm_valid && head == IDX_W'(i)) ent[i].valid <= 1'b0;
                if (disp_go && tail == IDX_W'(i)) ent[i] <= new_ent;
            end
            if (disp_go) tail <= step(tail);
            if (cm_valid) head <= step(head);
            case ({disp_go, cm_valid})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ruq_chk.sv
module ruq_chk #(
    parameter int DEPTH  = 16,
    parameter int NUM_FU = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              disp_valid,
    input logic              disp_full,
    input logic [NUM_FU-1:0] fu_ready,
    input logic [NUM_FU-1:0] iss_valid,
    input logic              cm_valid,
    input logic [IDX_W-1:0]  head,
    input logic [IDX_W-1:0]  tail,
    input logic [CNT_W-1:0]  count
);
    // R1: occupancy never exceeds capacity
    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R1: full persists until a retirement
    p_full_hold_r1: assert property (@(posedge clk) disable iff (rst)
        disp_full && !cm_valid |=> disp_full);

    // R1: dispatch while full leaves the tail in place
    p_full_blocks_r1: assert property (@(posedge clk) disable iff (rst)
        disp_full && disp_valid |=> tail == $past(tail));

    // R2: accepted dispatch moves the tail
    p_tail_step_r2: assert property (@(posedge clk) disable iff (rst)
        disp_valid && !disp_full |=> tail != $past(tail));

    // R6: no issue to a unit that is not ready
    p_fu_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (iss_valid & ~fu_ready) == '0);

    // R8: retirement moves the head
    p_head_step_r8: assert property (@(posedge clk) disable iff (rst)
        cm_valid |=> head != $past(head));

    // R8: nothing retires from an empty queue
    p_empty_idle_r8: assert property (@(posedge clk) disable iff (rst)
        count == '0 |-> !cm_valid);

    // R10: state right after reset
    p_reset_state_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == '0 && !cm_valid && iss_valid == '0));
endmodule

bind ruq_top ruq_chk #(.DEPTH(DEPTH), .NUM_FU(NUM_FU)) u_chk (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_full(disp_full),
    .fu_ready(fu_ready), .iss_valid(iss_valid), .cm_valid(cm_valid),
    .head(head), .tail(tail), .count(count)
);

// File: tb/ruq_top_bench.sv
`timescale 1ns/1ps
module ruq_top_bench;
    import ruq_pkg::*;

    localparam int DEPTH  = 4;
    localparam int NUM_FU = 2;
    localparam int IDX_W  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic                     disp_valid = 0;
    logic [PC_W-1:0]          disp_pc = 0;
    logic [FU_W-1:0]          disp_fu = 0;
    logic                     disp_mem = 0;
    logic                     disp_s1_rdy = 0, disp_s2_rdy = 0;
    logic [TAG_W-1:0]         disp_s1_tag = 0, disp_s2_tag = 0, disp_dst_tag = 0;
    logic [DATA_W-1:0]        disp_s1_val = 0, disp_s2_val = 0;
    logic                     disp_full;
    logic [IDX_W-1:0]         disp_idx;
    logic                     rb_valid = 0;
    logic [IDX_W-1:0]         rb_idx = 0;
    logic [TAG_W-1:0]         rb_tag = 0;
    logic [DATA_W-1:0]        rb_data = 0;
    logic [NUM_FU-1:0]        fu_ready = 0;
    logic [NUM_FU-1:0]        iss_valid;
    logic [NUM_FU*IDX_W-1:0]  iss_idx;
    logic [NUM_FU*PC_W-1:0]   iss_pc;
    logic [NUM_FU*DATA_W-1:0] iss_op1, iss_op2;
    logic [NUM_FU*TAG_W-1:0]  iss_dst_tag;
    logic                     cm_valid;
    logic [TAG_W-1:0]         cm_tag;
    logic [DATA_W-1:0]        cm_data;

    ruq_top #(.DEPTH(DEPTH), .NUM_FU(NUM_FU)) u_ruq_top (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct { logic [TAG_W-1:0] tag; logic [DATA_W-1:0] data; } exp_t;
    exp_t sb[$];

    task automatic chk(string req, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_iss(int f, int ei, longint e1, longint e2, longint et, string req);
        chk(req, iss_valid[f], 1);
        chk(req, iss_idx[f*IDX_W +: IDX_W], ei);
        chk(req, iss_op1[f*DATA_W +: DATA_W], e1);
        chk(req, iss_op2[f*DATA_W +: DATA_W], e2);
        chk(req, iss_dst_tag[f*TAG_W +: TAG_W], et);
    endtask

    // Driver: dispatch one instruction, push its expected retirement
    task automatic disp(int pc, int fu, bit mem, bit r1, int t1, int v1,
                        bit r2, int t2, int v2, int dst, int exp_data, int exp_idx);
        exp_t e;
        disp_valid = 1; disp_pc = PC_W'(pc); disp_fu = FU_W'(fu); disp_mem = mem;
        disp_s1_rdy = r1; disp_s1_tag = TAG_W'(t1); disp_s1_val = DATA_W'(v1);
        disp_s2_rdy = r2; disp_s2_tag = TAG_W'(t2); disp_s2_val = DATA_W'(v2);
        disp_dst_tag = TAG_W'(dst);
        e.tag = TAG_W'(dst); e.data = DATA_W'(exp_data);
        sb.push_back(e);
        @(negedge clk);
        chk("R2 dispatch index", disp_idx, exp_idx);
        chk("R1 not full before dispatch", disp_full, 0);
        tick();
        disp_valid = 0;
    endtask

    task automatic bus(int idx, int tag, int data);
        rb_valid = 1; rb_idx = IDX_W'(idx); rb_tag = TAG_W'(tag); rb_data = DATA_W'(data);
        tick();
        rb_valid = 0;
    endtask

    // Monitor: retirements compared against the scoreboard (R5, R8)
    always @(negedge clk) begin
        if (!rst && cm_valid) begin
            n_tests++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R8 unexpected retirement actual=%0h expected=none", cm_tag);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (cm_tag != e.tag || cm_data != e.data) begin
                    n_fail++;
                    $display("FAIL R5/R8 retirement actual=%0h/%0h expected=%0h/%0h",
                             cm_tag, cm_data, e.tag, e.data);
                end
            end
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R10 full after reset", disp_full, 0);
        chk("R10 retire after reset", cm_valid, 0);
        chk("R10 issue after reset", iss_valid, 0);
        chk("R10 index after reset", disp_idx, 0);
        tick();

        // Ready operands carried to issue, single issue (R3, R6, R5)
        disp(32'h100, 0, 0, 1, 0, 11, 1, 0, 22, 8'h10, 32'h33, 0);
        @(negedge clk); chk("R6 gated by fu_ready", iss_valid, 0); tick();
        fu_ready = 2'b01;
        @(negedge clk);
        chk_iss(0, 0, 11, 22, 8'h10, "R3 ready operands");
        chk("R3 pc", iss_pc[PC_W-1:0], 32'h100);
        tick();
        @(negedge clk); chk("R6 issued once", iss_valid, 0); tick();
        fu_ready = 0;
        bus(0, 8'h10, 32'h33);
        repeat (2) tick();

        // Age order and in-order retirement (R7, R8)
        disp(32'h200, 0, 0, 1, 0, 1, 1, 0, 2, 8'h21, 32'h111, 1);
        disp(32'h204, 0, 0, 1, 0, 3, 1, 0, 4, 8'h22, 32'h222, 2);
        fu_ready = 2'b01;
        @(negedge clk); chk_iss(0, 1, 1, 2, 8'h21, "R7 oldest first"); tick();
        @(negedge clk); chk_iss(0, 2, 3, 4, 8'h22, "R7 younger next"); tick();
        fu_ready = 0;
        bus(2, 8'h22, 32'h222);
        @(negedge clk); chk("R8 younger waits", cm_valid, 0); tick();
        @(negedge clk); chk("R8 younger still waits", cm_valid, 0); tick();
        bus(1, 8'h21, 32'h111);
        repeat (3) tick();

        // Fill with wrap, full, capture, memory priority (R1, R2, R4, R7)
        disp(32'h300, 1, 0, 0, 8'h33, 0, 1, 0, 5, 8'h31, 32'h3131, 3);
        disp(32'h304, 1, 1, 0, 8'h33, 0, 1, 0, 6, 8'h32, 32'h3232, 0);
        disp(32'h308, 1, 0, 1, 0, 7, 1, 0, 8, 8'h33, 32'h77, 1);
        disp(32'h30c, 0, 0, 0, 8'h31, 0, 1, 0, 9, 8'h34, 32'h3434, 2);
        @(negedge clk); chk("R1 full at capacity", disp_full, 1); tick();
        disp_valid = 1; disp_dst_tag = 8'h7f; disp_s1_rdy = 1; disp_s2_rdy = 1;
        tick();
        disp_valid = 0;
        @(negedge clk);
        chk("R1 dispatch ignored when full", disp_full, 1);
        chk("R1 tail unchanged when full", disp_idx, 3);
        chk("R6 no issue without fu_ready", iss_valid, 0);
        tick();
        fu_ready = 2'b10;
        @(negedge clk); chk_iss(1, 1, 7, 8, 8'h33, "R6 ready slot issues"); tick();
        @(negedge clk); chk("R4 waiting sources hold", iss_valid, 0); tick();
        bus(1, 8'h33, 32'h77);
        @(negedge clk); chk_iss(1, 0, 32'h77, 6, 8'h32, "R7 memory before older"); tick();
        @(negedge clk); chk_iss(1, 3, 32'h77, 5, 8'h31, "R4 captured operand"); tick();
        fu_ready = 0;
        bus(3, 8'h31, 32'h3131);
        @(negedge clk); chk("R1 full during retire cycle", disp_full, 1); tick();
        @(negedge clk); chk("R1 full clears after retire", disp_full, 0); tick();
        fu_ready = 2'b01;
        @(negedge clk); chk_iss(0, 2, 32'h3131, 9, 8'h34, "R4 capture by unit 0"); tick();
        fu_ready = 0;
        bus(0, 8'h32, 32'h3232);
        tick();
        bus(2, 8'h34, 32'h3434);
        repeat (3) tick();

        // Retirement broadcast and same-cycle result capture (R9, R4)
        disp(32'h400, 0, 0, 1, 0, 1, 1, 0, 1, 8'h50, 32'h5050, 3);
        bus(3, 8'h50, 32'h5050);
        disp(32'h404, 0, 0, 0, 8'h50, 0, 1, 0, 1, 8'h51, 32'h5151, 0);
        rb_valid = 1; rb_idx = 0; rb_tag = 8'h51; rb_data = 32'h5151;
        disp(32'h408, 1, 0, 0, 8'h51, 0, 1, 0, 2, 8'h52, 32'h5252, 1);
        rb_valid = 0;
        fu_ready = 2'b11;
        @(negedge clk);
        chk_iss(0, 0, 32'h5050, 1, 8'h51, "R9 retire broadcast");
        chk_iss(1, 1, 32'h5151, 2, 8'h52, "R4 capture at dispatch");
        tick();
        fu_ready = 0;
        bus(1, 8'h52, 32'h5252);
        repeat (3) tick();

        chk("R5 all retirements seen", sb.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule